// File: doc/BRIEF.md
# Keyed Configuration Index/Data Port

This block puts a configuration space behind a pair of byte-wide host I/O ports. The index port (address bit 0) chooses a register and the data port (address bit 1) reads or writes it. After reset the space is sealed. It opens only when the open key reaches the index port twice in a row, and the close key seals it again. While the space is sealed, reads return all ones and writes have no effect.

Indices below a global limit belong to the block itself:
- a logical-device number register;
- a read-only 16-bit device identifier;
- a revision byte;
- a 16-bit vendor identifier.

Indices at or above the limit pass through to one logical device on a simple banked bus. That bus carries the index, the write byte, the current logical-device number, and read and write strobes. A platform places the port pair at one of two fixed base addresses and decodes the base outside this block. The block sees only the low address bit.

Top module: `keyed_cfg_port`

## Requirements
- R1: After reset the space is sealed, the index register is 0x00 and the logical-device number is 0x00. A read on either port returns 0xFF.
- R2: Two consecutive index-port writes of 0x87 open the space. Accesses in the cycle after the second key see it open.
- R3: An index-port write of any byte other than 0x87 between the two keys restarts the sequence. Data-port accesses between the keys do not disturb it.
- R4: While sealed, reads on both ports return 0xFF. Data-port writes change no register and raise no bus strobe. Index-port writes do not load the index register.
- R5: While open, an index-port write of 0xAA seals the space from the next cycle and leaves the index register unchanged.
- R6: While open, an index-port write of any other byte loads the index register. An index-port read returns the index register.
- R7: Index 0x07 holds the logical-device number. It is readable and writable when open, and its value drives ld_num. The general-purpose I/O device is number 0x06.
- R8: Reads of the identification registers return fixed values:
  - 0x20: device ID high byte
  - 0x21: device ID low byte
  - 0x22: revision
  - 0x23: vendor high byte, 0x19
  - 0x24: vendor low byte, 0x34

  Writes to these registers are ignored. Any other index below 0x30 reads 0x00.
- R9: A data-port access at an index of 0x30 or above raises ld_rd or ld_wr in the same cycle, with ld_index, ld_wdata and ld_num valid. A read returns ld_rdata. Indices below 0x30 raise no strobe.
- R10: When a data-port read and write fall in the same cycle, the read returns the value held before the write, and the write takes effect at that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | Host write strobe, one cycle per access |
| io_rd | input | 1 | Host read strobe, one cycle per access |
| io_addr | input | 1 | 0 = index port, 1 = data port |
| io_wdata | input | 8 | Host write byte |
| io_rdata | output | 8 | Host read byte, valid in the strobe cycle |
| ld_num | output | 8 | Current logical-device number |
| ld_index | output | 8 | Register index toward the logical device |
| ld_wdata | output | 8 | Write byte toward the logical device |
| ld_wr | output | 1 | Forwarded write strobe |
| ld_rd | output | 1 | Forwarded read strobe |
| ld_rdata | input | 8 | Read byte from the logical device |

## Verification
A read and a write of the data port can land in the same cycle. Both the logical-device number register and a forwarded index are exposed to that collision. The bench raises both strobes together at index 0x07. It expects the old number on io_rdata in that cycle and the new number on the following read. At a forwarded index it expects both bus strobes in the one cycle. The close key against an open index read is a second collision. It is judged by requiring the sealed response only from the next cycle on.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    LK_SHUT = 2'd0,
    LK_HALF = 2'd1,
    LK_OPEN = 2'd2
  } lock_t;

  // Next state of the key sequencer for one index-port byte.
  function automatic lock_t lock_step(lock_t cur, logic [BYTE_W-1:0] b,
                                      logic [BYTE_W-1:0] kopen,
                                      logic [BYTE_W-1:0] kclose);
    case (cur)
      LK_SHUT: return (b == kopen)  ? LK_HALF : LK_SHUT;
      LK_HALF: return (b == kopen)  ? LK_OPEN : LK_SHUT;
      LK_OPEN: return (b == kclose) ? LK_SHUT : LK_OPEN;
      default: return LK_SHUT;
    endcase
  endfunction

  // Value of a locally decoded (global) register.
  function automatic logic [BYTE_W-1:0] global_byte(
      logic [BYTE_W-1:0]   idx,
      logic [BYTE_W-1:0]   ldn,
      logic [2*BYTE_W-1:0] dev_id,
      logic [BYTE_W-1:0]   rev,
      logic [2*BYTE_W-1:0] ven_id,
      logic [BYTE_W-1:0]   i_ldsel,
      logic [BYTE_W-1:0]   i_dev,
      logic [BYTE_W-1:0]   i_ven);
    logic [BYTE_W-1:0] r;
    r = '0;
    if (idx == i_ldsel)              r = ldn;
    else if (idx == i_dev)           r = dev_id[2*BYTE_W-1:BYTE_W];
    else if (idx == i_dev + 8'd1)    r = dev_id[BYTE_W-1:0];
    else if (idx == i_dev + 8'd2)    r = rev;
    else if (idx == i_ven)           r = ven_id[2*BYTE_W-1:BYTE_W];
    else if (idx == i_ven + 8'd1)    r = ven_id[BYTE_W-1:0];
    return r;
  endfunction
endpackage

// File: rtl/cfgport_key_seq.sv
module cfgport_key_seq
  import cfgport_pkg::*;
#(
  parameter logic [BYTE_W-1:0] KEY_OPEN  = 8'h87,
  parameter logic [BYTE_W-1:0] KEY_CLOSE = 8'hAA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idx_wr,
  input  logic [BYTE_W-1:0] wdata,
  output logic              open,
  output logic              key_hit_close
);
  lock_t state_q;
  lock_t state_d;

  always_comb begin
    state_d = state_q;
    if (idx_wr) state_d = lock_step(state_q, wdata, KEY_OPEN, KEY_CLOSE);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= LK_SHUT;
    else        state_q <= state_d;
  end

  assign open          = (state_q == LK_OPEN);
  assign key_hit_close = open & idx_wr & (wdata == KEY_CLOSE);
endmodule

// File: rtl/cfgport_select_regs.sv
module cfgport_select_regs
  import cfgport_pkg::*;
#(
  parameter logic [BYTE_W-1:0] RST_LDN = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idx_load,
  input  logic              ldsel_wr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] idx_q,
  output logic [BYTE_W-1:0] ldn_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
      ldn_q <= RST_LDN;
    end else begin
      if (idx_load) idx_q <= wdata;
      if (ldsel_wr) ldn_q <= wdata;
    end
  end
endmodule

// File: rtl/cfgport_route.sv
module cfgport_route
  import cfgport_pkg::*;
#(
  parameter logic [2*BYTE_W-1:0] DEV_ID       = 16'h0B27,
  parameter logic [BYTE_W-1:0]   DEV_REV      = 8'h03,
  parameter logic [2*BYTE_W-1:0] VEN_ID       = 16'h1934,
  parameter logic [BYTE_W-1:0]   IDX_LDSEL    = 8'h07,
  parameter logic [BYTE_W-1:0]   IDX_DEVID    = 8'h20,
  parameter logic [BYTE_W-1:0]   IDX_VENID    = 8'h23,
  parameter logic [BYTE_W-1:0]   GLOBAL_LIMIT = 8'h30
) (
  input  logic              open,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic              io_addr,
  input  logic [BYTE_W-1:0] idx_q,
  input  logic [BYTE_W-1:0] ldn_q,
  input  logic [BYTE_W-1:0] io_wdata,
  input  logic [BYTE_W-1:0] ld_rdata,
  output logic [BYTE_W-1:0] io_rdata,
  output logic              ld_rd,
  output logic              ld_wr,
  output logic [BYTE_W-1:0] ld_index,
  output logic [BYTE_W-1:0] ld_wdata,
  output logic [BYTE_W-1:0] ld_num
);
  localparam logic [BYTE_W-1:0] SEALED = '1;

  logic is_global;
  logic data_acc;

  assign is_global = (idx_q < GLOBAL_LIMIT);
  assign data_acc  = open & io_addr;
  assign ld_rd     = data_acc & io_rd & ~is_global;
  assign ld_wr     = data_acc & io_wr & ~is_global;
  assign ld_index  = idx_q;
  assign ld_wdata  = io_wdata;
  assign ld_num    = ldn_q;

  always_comb begin
    if (!open)          io_rdata = SEALED;
    else if (!io_addr)  io_rdata = idx_q;
    else if (is_global) io_rdata = global_byte(idx_q, ldn_q, DEV_ID, DEV_REV,
                                               VEN_ID, IDX_LDSEL, IDX_DEVID,
                                               IDX_VENID);
    else                io_rdata = ld_rdata;
  end
endmodule

// File: rtl/keyed_cfg_port.sv
module keyed_cfg_port
  import cfgport_pkg::*;
#(
  parameter logic [2*BYTE_W-1:0] DEV_ID       = 16'h0B27,
  parameter logic [BYTE_W-1:0]   DEV_REV      = 8'h03,
  parameter logic [2*BYTE_W-1:0] VEN_ID       = 16'h1934,
  parameter logic [BYTE_W-1:0]   KEY_OPEN     = 8'h87,
  parameter logic [BYTE_W-1:0]   KEY_CLOSE    = 8'hAA,
  parameter logic [BYTE_W-1:0]   IDX_LDSEL    = 8'h07,
  parameter logic [BYTE_W-1:0]   IDX_DEVID    = 8'h20,
  parameter logic [BYTE_W-1:0]   IDX_VENID    = 8'h23,
  parameter logic [BYTE_W-1:0]   GLOBAL_LIMIT = 8'h30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic              io_addr,
  input  logic [BYTE_W-1:0] io_wdata,
  output logic [BYTE_W-1:0] io_rdata,
  output logic [BYTE_W-1:0] ld_num,
  output logic [BYTE_W-1:0] ld_index,
  output logic [BYTE_W-1:0] ld_wdata,
  output logic              ld_wr,
  output logic              ld_rd,
  input  logic [BYTE_W-1:0] ld_rdata
);
  // Named internal events, also observed by the checker.
  logic              idx_wr;
  logic              dat_wr;
  logic              cfg_open;
  logic              key_hit_close;
  logic              idx_load;
  logic              ldsel_wr;
  logic [BYTE_W-1:0] idx_q;
  logic [BYTE_W-1:0] ldn_q;

  assign idx_wr   = io_wr & ~io_addr;
  assign dat_wr   = io_wr & io_addr;
  assign idx_load = cfg_open & idx_wr & ~key_hit_close;
  assign ldsel_wr = cfg_open & dat_wr & (idx_q == IDX_LDSEL);

  cfgport_key_seq #(
    .KEY_OPEN (KEY_OPEN),
    .KEY_CLOSE(KEY_CLOSE)
  ) u_key (
    .clk          (clk),
    .rst_n        (rst_n),
    .idx_wr       (idx_wr),
    .wdata        (io_wdata),
    .open         (cfg_open),
    .key_hit_close(key_hit_close)
  );

  cfgport_select_regs #(
    .RST_LDN(8'h00)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .idx_load(idx_load),
    .ldsel_wr(ldsel_wr),
    .wdata   (io_wdata),
    .idx_q   (idx_q),
    .ldn_q   (ldn_q)
  );

  cfgport_route #(
    .DEV_ID      (DEV_ID),
    .DEV_REV     (DEV_REV),
    .VEN_ID      (VEN_ID),
    .IDX_LDSEL   (IDX_LDSEL),
    .IDX_DEVID   (IDX_DEVID),
    .IDX_VENID   (IDX_VENID),
    .GLOBAL_LIMIT(GLOBAL_LIMIT)
  ) u_route (
    .open    (cfg_open),
    .io_rd   (io_rd),
    .io_wr   (io_wr),
    .io_addr (io_addr),
    .idx_q   (idx_q),
    .ldn_q   (ldn_q),
    .io_wdata(io_wdata),
    .ld_rdata(ld_rdata),
    .io_rdata(io_rdata),
    .ld_rd   (ld_rd),
    .ld_wr   (ld_wr),
    .ld_index(ld_index),
    .ld_wdata(ld_wdata),
    .ld_num  (ld_num)
  );
endmodule

// File: rtl/cfgport_checker.sv
module cfgport_checker #(
  parameter logic [7:0] KEY_OPEN     = 8'h87,
  parameter logic [7:0] KEY_CLOSE    = 8'hAA,
  parameter logic [7:0] IDX_LDSEL    = 8'h07,
  parameter logic [7:0] GLOBAL_LIMIT = 8'h30
) (
  input logic       clk,
  input logic       rst_n,
  input logic       io_wr,
  input logic       io_rd,
  input logic       io_addr,
  input logic [7:0] io_wdata,
  input logic [7:0] io_rdata,
  input logic       ld_wr,
  input logic       ld_rd,
  input logic [7:0] ld_index,
  input logic [7:0] ld_num,
  input logic       cfg_open,
  input logic [7:0] idx_q
);
  AST_SEALED_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_open |-> (!ld_wr && !ld_rd)); // R4

  AST_SEALED_READS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_open && io_rd) |-> (io_rdata == 8'hFF)); // R4

  AST_OPEN_AFTER_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_open) |-> $past(io_wr && !io_addr && io_wdata == KEY_OPEN)); // R2

  AST_CLOSE_KEY_SEALS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_open && io_wr && !io_addr && io_wdata == KEY_CLOSE) |=> !cfg_open); // R5

  AST_CLOSE_KEEPS_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_open && io_wr && !io_addr && io_wdata == KEY_CLOSE) |=> $stable(idx_q)); // R5

  AST_FWD_ABOVE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_wr || ld_rd) |-> (ld_index >= GLOBAL_LIMIT)); // R9

  AST_LDN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_open && io_wr && io_addr && idx_q == IDX_LDSEL) |=> $stable(ld_num)); // R7
endmodule

bind keyed_cfg_port cfgport_checker #(
  .KEY_OPEN    (KEY_OPEN),
  .KEY_CLOSE   (KEY_CLOSE),
  .IDX_LDSEL   (IDX_LDSEL),
  .GLOBAL_LIMIT(GLOBAL_LIMIT)
) u_chk (.*);

// File: tb/tb_keyed_cfg_port.sv
module tb_keyed_cfg_port;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;
  localparam logic [15:0] T_DEV = 16'h0B27;
  localparam logic [7:0]  T_REV = 8'h03;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       io_wr = 1'b0, io_rd = 1'b0, io_addr = 1'b0;
  logic [7:0] io_wdata = 8'h00;
  logic [7:0] io_rdata, ld_num, ld_index, ld_wdata, ld_rdata;
  logic       ld_wr, ld_rd;

  int tests = 0, fails = 0;
  int ld_wr_cnt = 0, ld_rd_cnt = 0;
  logic [7:0] cap_idx = 8'h00, cap_dat = 8'h00, cap_num = 8'h00;
  bit done = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  // Simple logical device model: read data is a function of the index.
  assign ld_rdata = ld_index ^ 8'h5A;

  keyed_cfg_port #(
    .DEV_ID(T_DEV), .DEV_REV(T_REV), .VEN_ID(16'h1934),
    .KEY_OPEN(8'h87), .KEY_CLOSE(8'hAA), .IDX_LDSEL(8'h07),
    .IDX_DEVID(8'h20), .IDX_VENID(8'h23), .GLOBAL_LIMIT(8'h30)
  ) dut (.*);

  always @(posedge clk) begin
    if (ld_wr) begin
      ld_wr_cnt <= ld_wr_cnt + 1;
      cap_idx <= ld_index; cap_dat <= ld_wdata; cap_num <= ld_num;
    end
    if (ld_rd) ld_rd_cnt <= ld_rd_cnt + 1;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: pops one expectation per read strobe.
  always @(negedge clk) begin
    if (rst_n && io_rd) begin
      if (exp_q.size() == 0) check(1'b0, "scoreboard-empty", io_rdata, 0);
      else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(io_rdata == e, t, io_rdata, e);
      end
    end
  end

  task automatic wr_port(input logic a, input logic [7:0] d);
    @(posedge clk); #1;
    io_wr = 1'b1; io_addr = a; io_wdata = d;
    @(posedge clk); #1;
    io_wr = 1'b0;
  endtask

  task automatic rd_port(input logic a, input logic [7:0] e, input string t);
    @(posedge clk); #1;
    exp_q.push_back(e); tag_q.push_back(t);
    io_rd = 1'b1; io_addr = a;
    @(posedge clk); #1;
    io_rd = 1'b0;
  endtask

  task automatic rdwr_data(input logic [7:0] d, input logic [7:0] e, input string t);
    @(posedge clk); #1;
    exp_q.push_back(e); tag_q.push_back(t);
    io_rd = 1'b1; io_wr = 1'b1; io_addr = 1'b1; io_wdata = d;
    @(posedge clk); #1;
    io_rd = 1'b0; io_wr = 1'b0;
  endtask

  task automatic unlock();
    wr_port(1'b0, 8'h87);
    wr_port(1'b0, 8'h87);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd_port(1'b1, 8'hFF, "R1 data read after reset");
    rd_port(1'b0, 8'hFF, "R1 index read after reset");
    #1 check(ld_num == 8'h00, "R1 ld_num reset", ld_num, 0);

    // R4 sealed: writes ignored, no strobes
    wr_port(1'b0, 8'h07);
    wr_port(1'b1, 8'h06);
    wr_port(1'b0, 8'h40);
    wr_port(1'b1, 8'h11);
    rd_port(1'b1, 8'hFF, "R4 sealed data read");
    check(ld_wr_cnt == 0 && ld_rd_cnt == 0, "R4 no strobe while sealed", ld_wr_cnt, 0);
    check(ld_num == 8'h00, "R4 ld_num untouched while sealed", ld_num, 0);

    // R3 data access between keys does not disturb; R2 opens
    wr_port(1'b0, 8'h87);
    rd_port(1'b1, 8'hFF, "R3 still sealed between keys");
    wr_port(1'b0, 8'h87);
    rd_port(1'b0, 8'h00, "R2 open, R4 index not loaded while sealed");

    // R5 close key, R3 broken sequence
    wr_port(1'b0, 8'hAA);
    rd_port(1'b0, 8'hFF, "R5 sealed after close key");
    wr_port(1'b0, 8'h87);
    wr_port(1'b0, 8'h55);
    wr_port(1'b0, 8'h87);
    rd_port(1'b1, 8'hFF, "R3 sequence restarted");
    wr_port(1'b0, 8'h87);
    rd_port(1'b0, 8'h00, "R2 open after restarted pair");

    // R6 / R7 logical-device number
    wr_port(1'b0, 8'h07);
    rd_port(1'b0, 8'h07, "R6 index readback");
    rd_port(1'b1, 8'h00, "R7 ldn reset value");
    wr_port(1'b1, 8'h06);
    rd_port(1'b1, 8'h06, "R7 ldn written");
    check(ld_num == 8'h06, "R7 ld_num port", ld_num, 8'h06);

    // R8 identification
    wr_port(1'b0, 8'h20); rd_port(1'b1, T_DEV[15:8], "R8 dev hi");
    wr_port(1'b0, 8'h21); rd_port(1'b1, T_DEV[7:0],  "R8 dev lo");
    wr_port(1'b0, 8'h22); rd_port(1'b1, T_REV,       "R8 revision");
    wr_port(1'b0, 8'h24); rd_port(1'b1, 8'h34,       "R8 vendor lo");
    wr_port(1'b0, 8'h23); rd_port(1'b1, 8'h19,       "R8 vendor hi");
    wr_port(1'b1, 8'h00); rd_port(1'b1, 8'h19,       "R8 vendor read-only");
    wr_port(1'b0, 8'h10); rd_port(1'b1, 8'h00,       "R8 unused global");
    wr_port(1'b1, 8'hEE);
    check(ld_wr_cnt == 0 && ld_rd_cnt == 0, "R9 no strobe for globals", ld_wr_cnt + ld_rd_cnt, 0);

    // R9 forwarding
    wr_port(1'b0, 8'h35);
    rd_port(1'b1, 8'h35 ^ 8'h5A, "R9 forwarded read data");
    check(ld_rd_cnt == 1, "R9 one read strobe", ld_rd_cnt, 1);
    wr_port(1'b1, 8'hC3);
    check(ld_wr_cnt == 1, "R9 one write strobe", ld_wr_cnt, 1);
    check(cap_idx == 8'h35 && cap_dat == 8'hC3 && cap_num == 8'h06,
          "R9 forwarded write fields", {cap_idx, cap_dat, cap_num}, 24'h35C306);
    wr_port(1'b0, 8'h30);
    rdwr_data(8'h44, 8'h30 ^ 8'h5A, "R10 forwarded read with write");
    check(ld_rd_cnt == 2 && ld_wr_cnt == 2, "R10 both strobes same cycle",
          ld_rd_cnt * 16 + ld_wr_cnt, 8'h22);

    // R10 simultaneous on ldn register
    wr_port(1'b0, 8'h07);
    rdwr_data(8'h02, 8'h06, "R10 read returns old ldn");
    rd_port(1'b1, 8'h02, "R10 new ldn after write");

    // R5 close keeps index; R4 sealed write ignored
    wr_port(1'b0, 8'hAA);
    rd_port(1'b1, 8'hFF, "R5 data sealed");
    wr_port(1'b1, 8'h09);
    unlock();
    rd_port(1'b0, 8'h07, "R5 index kept over close");
    rd_port(1'b1, 8'h02, "R4 sealed data write ignored");

    repeat (2) @(posedge clk);
    check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule